// File: doc/BRIEF.md
# Transmit Jabber Watchdog Timer

This block guards a transmitter against a packet that never ends. It samples a transmit-active indication on every clock edge and times each continuous burst of activity. While a burst stays under the jabber limit, the transmitter enable stays high. A burst that reaches the limit drops the enable and raises a fault request for the collision signalling path. The request stays up for as long as the input stays active.

Once the input goes quiet, the fault request clears, but the transmitter stays disabled. It is enabled again only after an unbroken run of quiet cycles equal to the unjab limit. Any activity during that wait starts the wait over. Both limits are parameters in clock cycles. On a 10 MHz timebase the defaults correspond to about 29 ms and 500 ms. A bench can shorten them.

Top module: `tx_jabber_guard`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, tx_enable_o is 1 and jabber_fault_o is 0.
- R2: When tx_active_i is sampled 1 on JAB_LIMIT consecutive rising edges while enabled, tx_enable_o is 0 and jabber_fault_o is 1 right after the last of those edges. A burst of JAB_LIMIT-1 edges leaves tx_enable_o at 1.
- R3: A single edge with tx_active_i sampled 0 clears the activity count, so each burst is timed on its own.
- R4: After a jab, jabber_fault_o stays 1 and tx_enable_o stays 0 for every further edge on which tx_active_i is sampled 1.
- R5: The first edge with tx_active_i sampled 0 after a jab clears jabber_fault_o. tx_enable_o returns to 1 right after UNJAB_LIMIT consecutive edges with tx_active_i sampled 0, and not earlier. The first of those edges is the one that cleared the fault.
- R6: An edge with tx_active_i sampled 1 during the unjab wait restarts the quiet count from zero. It keeps tx_enable_o at 0 and does not reassert jabber_fault_o.
- R7: jabber_fault_o and tx_enable_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_active_i | input | 1 | Transmitter is currently sending |
| tx_enable_o | output | 1 | Transmitter gate, 1 = allowed |
| jabber_fault_o | output | 1 | Collision output request during a jab |

## Verification
The hardest case to reach is a pulse of activity that lands late in the unjab wait. Such a pulse must restart the wait and not be mistaken for a new fault. The stimulus first forces a jab with a burst of exactly JAB_LIMIT cycles. It then holds the input quiet for one cycle less than the unjab limit and injects a single active cycle. After that it counts out the full unjab limit again and checks that the enable comes back on exactly the last quiet edge. Shortened limits keep these windows to tens of cycles.

// File: rtl/tx_jabber_pkg.sv
package tx_jabber_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TX_OK  = 2'd1,
    ST_JABBED = 2'd2,
    ST_UNJAB  = 2'd3
  } jab_state_e;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_CLEAR = 2'd1,
    CNT_ONE   = 2'd2,
    CNT_INC   = 2'd3
  } cnt_op_e;

  function automatic int unsigned cnt_width(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/jab_cycle_counter.sv
module jab_cycle_counter
  import tx_jabber_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cnt_op_e       op_i,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        CNT_CLEAR: cnt_q <= '0;
        CNT_ONE:   cnt_q <= CW'(1);
        CNT_INC:   cnt_q <= cnt_q + CW'(1);
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/jab_ctrl_fsm.sv
module jab_ctrl_fsm
  import tx_jabber_pkg::*;
#(
  parameter int unsigned CW          = 8,
  parameter int unsigned JAB_LIMIT   = 20,
  parameter int unsigned UNJAB_LIMIT = 50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_active_i,
  input  logic [CW-1:0] cnt_i,
  output cnt_op_e       op_o,
  output jab_state_e    state_o
);

  localparam logic [CW-1:0] JabLast   = CW'(JAB_LIMIT - 1);
  localparam logic [CW-1:0] UnjabLast = CW'(UNJAB_LIMIT - 1);

  jab_state_e state_q, state_d;
  cnt_op_e    op;

  always_comb begin
    state_d = state_q;
    op      = CNT_HOLD;
    unique case (state_q)
      ST_IDLE: begin
        if (tx_active_i) begin
          state_d = ST_TX_OK;
          op      = CNT_ONE;
        end
      end
      ST_TX_OK: begin
        if (!tx_active_i) begin
          state_d = ST_IDLE;
          op      = CNT_CLEAR;
        end else if (cnt_i >= JabLast) begin
          state_d = ST_JABBED;
          op      = CNT_CLEAR;
        end else begin
          op = CNT_INC;
        end
      end
      ST_JABBED: begin
        if (!tx_active_i) begin
          state_d = ST_UNJAB;
          op      = CNT_ONE;  // this quiet edge is the first of the wait
        end
      end
      ST_UNJAB: begin
        if (tx_active_i) begin
          op = CNT_CLEAR;
        end else if (cnt_i >= UnjabLast) begin
          state_d = ST_IDLE;
          op      = CNT_CLEAR;
        end else begin
          op = CNT_INC;
        end
      end
      default: begin
        state_d = ST_IDLE;
        op      = CNT_CLEAR;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign op_o    = op;
  assign state_o = state_q;

endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard
  import tx_jabber_pkg::*;
#(
  parameter int unsigned JAB_LIMIT   = 290000,
  parameter int unsigned UNJAB_LIMIT = 5000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_active_i,
  output logic tx_enable_o,
  output logic jabber_fault_o
);

  localparam int unsigned CW = cnt_width(JAB_LIMIT, UNJAB_LIMIT);

  initial begin
    if (JAB_LIMIT < 2 || UNJAB_LIMIT < 2)
      $error("tx_jabber_guard: limits must be at least 2");
  end

  cnt_op_e       op;
  jab_state_e    state;
  logic [CW-1:0] cnt;

  jab_cycle_counter #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .cnt_o  (cnt)
  );

  jab_ctrl_fsm #(
    .CW          (CW),
    .JAB_LIMIT   (JAB_LIMIT),
    .UNJAB_LIMIT (UNJAB_LIMIT)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_active_i (tx_active_i),
    .cnt_i       (cnt),
    .op_o        (op),
    .state_o     (state)
  );

  assign tx_enable_o    = (state == ST_IDLE) || (state == ST_TX_OK);
  assign jabber_fault_o = (state == ST_JABBED);

endmodule

// File: rtl/tx_jabber_guard_chk.sv
module tx_jabber_guard_chk #(
  parameter int unsigned JAB_LIMIT   = 20,
  parameter int unsigned UNJAB_LIMIT = 50
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_active_i,
  input logic tx_enable_o,
  input logic jabber_fault_o
);

  localparam int unsigned RW = $clog2(((JAB_LIMIT > UNJAB_LIMIT) ? JAB_LIMIT : UNJAB_LIMIT) + 2);
  localparam logic [RW-1:0] RMAX = {RW{1'b1}};

  logic [RW-1:0] run_q, quiet_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      quiet_q <= '0;
    end else if (tx_active_i) begin
      quiet_q <= '0;
      if (run_q != RMAX) run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
      if (quiet_q != RMAX) quiet_q <= quiet_q + 1'b1;
    end
  end

  p_jab_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q >= RW'(JAB_LIMIT)) |-> !tx_enable_o);

  p_fault_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jabber_fault_o) |-> ($past(tx_active_i) && $fell(tx_enable_o)));

  p_fault_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jabber_fault_o && tx_active_i) |=> jabber_fault_o);

  p_fault_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(jabber_fault_o) |-> ($past(!tx_active_i) && !tx_enable_o));

  p_reenable_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_enable_o) |-> (quiet_q >= RW'(UNJAB_LIMIT)));

  p_active_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_enable_o && !jabber_fault_o && tx_active_i) |=> (!tx_enable_o && !jabber_fault_o));

  p_fault_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(jabber_fault_o && tx_enable_o));

endmodule

bind tx_jabber_guard tx_jabber_guard_chk #(
  .JAB_LIMIT   (JAB_LIMIT),
  .UNJAB_LIMIT (UNJAB_LIMIT)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tx_active_i    (tx_active_i),
  .tx_enable_o    (tx_enable_o),
  .jabber_fault_o (jabber_fault_o)
);

// File: tb/tx_jabber_guard_tb_top.sv
module tx_jabber_guard_tb_top;

  localparam int JAB   = 20;
  localparam int UNJAB = 50;
  localparam int NV    = 13;

  // per vector: input level, edge count, expected enable, expected fault, requirement
  localparam int V_A[NV]   = '{0, 1, 0, 1, 1, 1, 0, 0, 1, 0, 0, 1, 0};
  localparam int V_N[NV]   = '{5, JAB-1, 1, JAB-1, 1, 30, 1, UNJAB-2, 1, UNJAB-1, 1, JAB, UNJAB};
  localparam int V_E[NV]   = '{1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 1};
  localparam int V_F[NV]   = '{0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 1, 0};
  localparam int V_R[NV]   = '{1, 2, 3, 3, 2, 4, 5, 5, 6, 6, 5, 2, 5};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic tx_active_i = 1'b0;
  logic tx_enable_o, jabber_fault_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #5 clk_i = ~clk_i;

  tx_jabber_guard #(.JAB_LIMIT(JAB), .UNJAB_LIMIT(UNJAB)) dut_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tx_active_i    (tx_active_i),
    .tx_enable_o    (tx_enable_o),
    .jabber_fault_o (jabber_fault_o)
  );

  task automatic check(input string req, input logic exp_en, input logic exp_f);
    n_tests++;
    if (tx_enable_o !== exp_en || jabber_fault_o !== exp_f) begin
      n_fail++;
      $display("FAIL %s: en=%b fault=%b expected en=%b fault=%b at %0t",
               req, tx_enable_o, jabber_fault_o, exp_en, exp_f, $time);
    end
  endtask

  // drive level a for n rising edges, starting and ending at a falling edge
  task automatic run(input logic a, input int n);
    for (int i = 0; i < n; i++) begin
      tx_active_i = a;
      @(negedge clk_i);
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    #2 check("R1", 1'b1, 1'b0);
    repeat (3) @(negedge clk_i);
    check("R1", 1'b1, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 1'b1, 1'b0);

    for (int v = 0; v < NV; v++) begin
      run(V_A[v][0], V_N[v]);
      check($sformatf("R%0d vec%0d", V_R[v], v), V_E[v][0], V_F[v][0]);
    end

    // R7: mutual exclusion sampled through a jab and recovery
    for (int i = 0; i < JAB + 5; i++) begin
      run(1'b1, 1);
      if (tx_enable_o && jabber_fault_o) check("R7", 1'b0, 1'b1);
    end
    check("R4", 1'b0, 1'b1);

    // R1: reset in the middle of a fault
    rst_ni = 1'b0;
    #1 check("R1 async", 1'b1, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run(1'b1, JAB - 1);
    check("R2 after reset", 1'b1, 1'b0);
    run(1'b1, 1);
    check("R2 after reset", 1'b0, 1'b1);

    // R6: pulse on the very last quiet edge of the wait
    run(1'b0, UNJAB - 1);
    check("R5", 1'b0, 1'b0);
    run(1'b1, 1);
    check("R6 late pulse", 1'b0, 1'b0);
    run(1'b0, UNJAB - 1);
    check("R6", 1'b0, 1'b0);
    run(1'b0, 1);
    check("R5 exact", 1'b1, 1'b0);

    // R3: alternating short bursts never jab
    for (int k = 0; k < 4; k++) begin
      run(1'b1, JAB - 1);
      run(1'b0, 1);
    end
    check("R3 repeated", 1'b1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule